// File: doc/BRIEF.md
# Raster Timing Controller with Indexed Register File

This block generates the raster timing for a character-cell display. A host programs it through an indexed port: one strobe loads an index, a second strobe writes a data byte into the register that index selects. Twenty-five registers, indices 0x00 to 0x18, hold the horizontal and vertical limits, the scan-line geometry, the display start and cursor addresses and the vertical interrupt control. The vertical limits are ten bits wide and are assembled from a low byte plus high bits held in a shared overflow register and in the scan-line register.

Every clock is one character clock. A horizontal character counter and a vertical line counter drive display enable, horizontal and vertical blank, horizontal and vertical sync and a vertical interrupt. A row-scan counter walks the lines of each character row and a row base address steps by the row offset at each row wrap. The output memory address is the row base plus the character counter. A line-compare value restarts the address at zero partway down the frame for a split screen, and a cursor flag marks the character cell at the cursor address within the cursor's scan-line band.

Top module: `crtc_core`

## Requirements
- R1: `idx_we` loads `wdata` as the index. `dat_we` writes `wdata` into register `index` when index ≤ 0x18. A data write with a larger index changes no register. All registers, the index, the counters, the row base and the interrupt reset to zero.
- R2: While bit 7 of register 0x11 is 1, data writes to indices 0x00..0x07 are ignored, except that a write to 0x07 still updates bit 4 of 0x07, which is line-compare bit 8.
- R3: `h_count` counts 0 up to reg0x00+4 and then returns to 0. At each such end of line, `v_count` steps up by one, returning to 0 after it reaches VT+1. VT = {0x07[5], 0x07[0], 0x06}.
- R4: `disp_en` is 1 exactly when `h_count` ≤ reg0x01 and `v_count` ≤ {0x07[6], 0x07[1], 0x12}.
- R5: `hblank` rises in the cycle where `h_count` equals reg0x02. It stays high until the first cycle in which `h_count[5:0]` equals {0x05[7], 0x03[4:0]}, and that cycle is not blanked.
- R6: `hsync` rises in the cycle where `h_count` equals reg0x04. It stays high until the first cycle in which `h_count[4:0]` equals 0x05[4:0].
- R7: `vblank` rises on lines where `v_count` equals {0x09[5], 0x07[3], 0x15}. It holds until the first line on which `v_count[6:0]` equals 0x16[6:0].
- R8: `vsync` rises on lines where `v_count` equals {0x07[7], 0x07[2], 0x10}. It holds until the first line on which `v_count[3:0]` equals 0x11[3:0]. `vint` is set one cycle after `vsync` rises, provided 0x11[5] is 0. It is held at 0 from the cycle after 0x11[4] becomes 0.
- R9: At each end of line, `row_scan` counts 0..0x09[4:0]. When 0x09[7] is 1, each value is held for two lines. At the wrap, the row base grows by reg0x13. At the end of the last line of a frame, the row base loads {0x0C, 0x0D}. `mem_addr` = row base + `h_count`.
- R10: When the line about to start equals line compare {0x09[6], 0x07[4], 0x18}, the row base and `row_scan` both restart at 0. This takes priority over the frame-start load.
- R11: `cursor` is 1 when all of the following hold: `disp_en` is 1, 0x0A[5] is 0, `mem_addr` equals {0x0E, 0x0F}, and 0x0A[4:0] ≤ `row_scan` ≤ 0x0B[4:0].
- R12: Blank, sync and the counters are registered with synchronous active-low reset. All outputs are valid in the first cycle after reset, derived from all-zero registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idx_we | input | 1 | Load `wdata` as register index |
| dat_we | input | 1 | Write `wdata` into the indexed register |
| wdata | input | 8 | Host write byte |
| h_count | output | 8 | Character counter |
| v_count | output | 10 | Line counter |
| disp_en | output | 1 | Active display region |
| hblank | output | 1 | Horizontal blank |
| hsync | output | 1 | Horizontal sync |
| vblank | output | 1 | Vertical blank |
| vsync | output | 1 | Vertical sync |
| vint | output | 1 | Pending vertical interrupt |
| row_scan | output | 5 | Scan line within the character row |
| mem_addr | output | 16 | Display memory address |
| cursor | output | 1 | Cursor cell and scan-line hit |

## Verification
The assertions assume the host never raises `idx_we` and `dat_we` in the same cycle. They also assume that a register is written only through a preceding index load. The bench's write task always spends one cycle on the index and a separate cycle on the data, so both conditions hold for all stimulus. The span and split-screen properties also tolerate register changes in mid-line, because they compare only against values present in the same cycle. The bench reprograms registers while the raster runs, so limits move under a live counter.

// File: rtl/crtc_pkg.sv
// Shared widths, register indices and the decoded configuration record.
// Assumes a fixed 25-entry register file; the bit positions of the
// overflow and scan-line registers are behaviour and stay fixed.
package crtc_pkg;
    localparam int DW     = 8;   // host data width
    localparam int HW     = 8;   // character counter width
    localparam int VW     = 10;  // line counter width
    localparam int AW     = 16;  // memory address width
    localparam int RW     = 5;   // row-scan width
    localparam int NREG   = 25;  // indices 0x00..0x18
    localparam int IXB    = $clog2(NREG);
    localparam int HBE_W  = 6;   // bits compared for horizontal blank end
    localparam int HSE_W  = 5;   // bits compared for horizontal sync end
    localparam int VBE_W  = 7;   // bits compared for vertical blank end
    localparam int VSE_W  = 4;   // bits compared for vertical sync end
    localparam int PROT_LAST = 7; // last index covered by write protect

    localparam int IX_HTOT = 0,  IX_HDE  = 1,  IX_HBS = 2,  IX_HBE = 3;
    localparam int IX_HSS  = 4,  IX_HSE  = 5,  IX_VTOT = 6, IX_OVF = 7;
    localparam int IX_MSL  = 9,  IX_CURS = 10, IX_CURE = 11;
    localparam int IX_SAH  = 12, IX_SAL  = 13, IX_CAH = 14, IX_CAL = 15;
    localparam int IX_VSS  = 16, IX_VRE  = 17, IX_VDE = 18, IX_OFS = 19;
    localparam int IX_VBS  = 21, IX_VBE  = 22, IX_LC  = 24;
    localparam int LC8_BIT = 4;  // overflow bit that ignores write protect

    typedef struct packed {
        logic [HW-1:0]    h_total;
        logic [HW-1:0]    h_disp_end;
        logic [HW-1:0]    h_blank_start;
        logic [HBE_W-1:0] h_blank_end;
        logic [HW-1:0]    h_sync_start;
        logic [HSE_W-1:0] h_sync_end;
        logic [VW-1:0]    v_total;
        logic [VW-1:0]    v_disp_end;
        logic [VW-1:0]    v_blank_start;
        logic [VBE_W-1:0] v_blank_end;
        logic [VW-1:0]    v_sync_start;
        logic [VSE_W-1:0] v_sync_end;
        logic [VW-1:0]    line_cmp;
        logic [RW-1:0]    max_scan;
        logic             dbl_scan;
        logic [AW-1:0]    start_addr;
        logic [AW-1:0]    cur_addr;
        logic [RW-1:0]    cur_first;
        logic [RW-1:0]    cur_last;
        logic             cur_hide;
        logic [DW-1:0]    row_offset;
        logic             vint_keep;
        logic             vint_dis;
    } crtc_cfg_t;
endpackage

// File: rtl/crtc_regfile.sv
// Indexed register file with write protect and field assembly.
// Assumes idx_we and dat_we are never high in the same cycle.
module crtc_regfile
    import crtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_we,
    input  logic          dat_we,
    input  logic [DW-1:0] wdata,
    output crtc_cfg_t     cfg
);
    logic [DW-1:0] regs [NREG];
    logic [DW-1:0] idx_q;
    logic          hit;
    logic          locked;
    logic          wprot;

    assign wprot  = regs[IX_VRE][7];
    assign hit    = (idx_q < DW'(NREG));
    assign locked = wprot && (idx_q <= DW'(PROT_LAST));

    // Host port: index load and guarded data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            if (idx_we) idx_q <= wdata;
            if (dat_we && hit) begin
                if (locked) begin
                    if (idx_q == DW'(IX_OVF))
                        regs[IX_OVF][LC8_BIT] <= wdata[LC8_BIT];
                end else begin
                    regs[idx_q[IXB-1:0]] <= wdata;
                end
            end
        end
    end

    // Field assembly: ten-bit vertical values from low byte plus overflow bits.
    always_comb begin
        cfg.h_total       = regs[IX_HTOT];
        cfg.h_disp_end    = regs[IX_HDE];
        cfg.h_blank_start = regs[IX_HBS];
        cfg.h_blank_end   = {regs[IX_HSE][7], regs[IX_HBE][4:0]};
        cfg.h_sync_start  = regs[IX_HSS];
        cfg.h_sync_end    = regs[IX_HSE][4:0];
        cfg.v_total       = {regs[IX_OVF][5], regs[IX_OVF][0], regs[IX_VTOT]};
        cfg.v_disp_end    = {regs[IX_OVF][6], regs[IX_OVF][1], regs[IX_VDE]};
        cfg.v_sync_start  = {regs[IX_OVF][7], regs[IX_OVF][2], regs[IX_VSS]};
        cfg.v_sync_end    = regs[IX_VRE][3:0];
        cfg.v_blank_start = {regs[IX_MSL][5], regs[IX_OVF][3], regs[IX_VBS]};
        cfg.v_blank_end   = regs[IX_VBE][6:0];
        cfg.line_cmp      = {regs[IX_MSL][6], regs[IX_OVF][4], regs[IX_LC]};
        cfg.max_scan      = regs[IX_MSL][4:0];
        cfg.dbl_scan      = regs[IX_MSL][7];
        cfg.start_addr    = {regs[IX_SAH], regs[IX_SAL]};
        cfg.cur_addr      = {regs[IX_CAH], regs[IX_CAL]};
        cfg.cur_first     = regs[IX_CURS][4:0];
        cfg.cur_hide      = regs[IX_CURS][5];
        cfg.cur_last      = regs[IX_CURE][4:0];
        cfg.row_offset    = regs[IX_OFS];
        cfg.vint_keep     = regs[IX_VRE][4];
        cfg.vint_dis      = regs[IX_VRE][5];
    end

    // R2: a protected write leaves the horizontal total untouched.
    a_r2_prot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && wprot && idx_q == DW'(IX_HTOT)) |=> $stable(cfg.h_total));
    // R2: line-compare bit 8 follows every write to the overflow register.
    a_r2_lc8_free: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && idx_q == DW'(IX_OVF)) |=> (cfg.line_cmp[8] == $past(wdata[LC8_BIT])));
    // R1: a data write beyond the last index changes nothing.
    a_r1_high_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && idx_q >= DW'(NREG)) |=> $stable(cfg));
endmodule

// File: rtl/crtc_span.sv
// Set/hold window: opens when the full counter matches a start value,
// closes when the low EW bits match an end value. Assumes EW <= CW.
module crtc_span #(
    parameter int CW = 8,
    parameter int EW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] start,
    input  logic [EW-1:0] stop,
    output logic          active
);
    logic held;

    assign active = (cnt == start) || (held && (cnt[EW-1:0] != stop));

    // Window memory from the previous character clock.
    always_ff @(posedge clk) begin
        if (!rst_n) held <= 1'b0;
        else        held <= active;
    end

    // R5, R6, R7, R8: a window only opens on its start match.
    a_r5_span_begin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (cnt == start));
endmodule

// File: rtl/crtc_sweep.sv
// Horizontal and vertical counters, the four blank/sync windows,
// display enable and the vertical interrupt latch.
// Assumes one character per clock.
module crtc_sweep
    import crtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HW-1:0]    h_total,
    input  logic [HW-1:0]    h_disp_end,
    input  logic [HW-1:0]    h_blank_start,
    input  logic [HBE_W-1:0] h_blank_end,
    input  logic [HW-1:0]    h_sync_start,
    input  logic [HSE_W-1:0] h_sync_end,
    input  logic [VW-1:0]    v_total,
    input  logic [VW-1:0]    v_disp_end,
    input  logic [VW-1:0]    v_blank_start,
    input  logic [VBE_W-1:0] v_blank_end,
    input  logic [VW-1:0]    v_sync_start,
    input  logic [VSE_W-1:0] v_sync_end,
    input  logic             vint_keep,
    input  logic             vint_dis,
    output logic [HW-1:0]    h,
    output logic [VW-1:0]    v,
    output logic [VW-1:0]    v_next,
    output logic             eol,
    output logic             eof,
    output logic             disp_en,
    output logic             hblank,
    output logic             hsync,
    output logic             vblank,
    output logic             vsync,
    output logic             vint
);
    localparam logic [HW-1:0] H_EXTRA = HW'(4);
    localparam logic [VW-1:0] V_EXTRA = VW'(1);

    logic [HW-1:0] h_q;
    logic [VW-1:0] v_q;
    logic [HW-1:0] h_last;
    logic [VW-1:0] v_last;
    logic          vs_q;
    logic          pend_q;

    assign h_last = h_total + H_EXTRA;
    assign v_last = v_total + V_EXTRA;
    assign eol    = (h_q == h_last);
    assign eof    = eol && (v_q == v_last);
    assign v_next = eol ? (eof ? '0 : v_q + VW'(1)) : v_q;

    // Character and line counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= '0;
        end else begin
            h_q <= eol ? '0 : h_q + HW'(1);
            v_q <= v_next;
        end
    end

    crtc_span #(.CW(HW), .EW(HBE_W)) u_hblank (
        .clk(clk), .rst_n(rst_n), .cnt(h_q), .start(h_blank_start),
        .stop(h_blank_end), .active(hblank));
    crtc_span #(.CW(HW), .EW(HSE_W)) u_hsync (
        .clk(clk), .rst_n(rst_n), .cnt(h_q), .start(h_sync_start),
        .stop(h_sync_end), .active(hsync));
    crtc_span #(.CW(VW), .EW(VBE_W)) u_vblank (
        .clk(clk), .rst_n(rst_n), .cnt(v_q), .start(v_blank_start),
        .stop(v_blank_end), .active(vblank));
    crtc_span #(.CW(VW), .EW(VSE_W)) u_vsync (
        .clk(clk), .rst_n(rst_n), .cnt(v_q), .start(v_sync_start),
        .stop(v_sync_end), .active(vsync));

    // Vertical interrupt: latch on sync rise, held clear while keep is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            vs_q <= vsync;
            if (!vint_keep)                        pend_q <= 1'b0;
            else if (vsync && !vs_q && !vint_dis)  pend_q <= 1'b1;
        end
    end

    assign disp_en = (h_q <= h_disp_end) && (v_q <= v_disp_end);
    assign h       = h_q;
    assign v       = v_q;
    assign vint    = pend_q;

    // R3: the line counter only moves as a new line starts.
    a_r3_v_line_start: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q != $past(v_q)) |-> (h_q == '0));
    // R8: a low keep bit holds the interrupt clear.
    a_r8_vint_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vint_keep |=> !vint);
endmodule

// File: rtl/crtc_rowaddr.sv
// Row-scan counter, row base address with split-screen restart,
// memory address and cursor hit. Assumes eol/eof/v_next come from the sweep.
module crtc_rowaddr
    import crtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eol,
    input  logic          eof,
    input  logic [VW-1:0] v_next,
    input  logic [HW-1:0] h,
    input  logic          disp_en,
    input  logic [VW-1:0] line_cmp,
    input  logic [RW-1:0] max_scan,
    input  logic          dbl_scan,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] row_offset,
    input  logic [AW-1:0] cur_addr,
    input  logic [RW-1:0] cur_first,
    input  logic [RW-1:0] cur_last,
    input  logic          cur_hide,
    output logic [RW-1:0] row_scan,
    output logic [AW-1:0] mem_addr,
    output logic          cursor
);
    logic [RW-1:0] rs_q;
    logic          dbl_q;
    logic [AW-1:0] base_q;

    // Per-line update: split restart, frame reload, doubling, row step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q   <= '0;
            dbl_q  <= 1'b0;
            base_q <= '0;
        end else if (eol) begin
            if (v_next == line_cmp) begin
                rs_q   <= '0;
                dbl_q  <= 1'b0;
                base_q <= '0;
            end else if (eof) begin
                rs_q   <= '0;
                dbl_q  <= 1'b0;
                base_q <= start_addr;
            end else if (dbl_scan && !dbl_q) begin
                dbl_q <= 1'b1;
            end else begin
                dbl_q <= 1'b0;
                if (rs_q == max_scan) begin
                    rs_q   <= '0;
                    base_q <= base_q + AW'(row_offset);
                end else begin
                    rs_q <= rs_q + RW'(1);
                end
            end
        end
    end

    assign mem_addr = base_q + AW'(h);
    assign row_scan = rs_q;
    assign cursor   = disp_en && !cur_hide && (mem_addr == cur_addr)
                      && (rs_q >= cur_first) && (rs_q <= cur_last);

    // R10: entering the compare line restarts address and row scan.
    a_r10_split: assert property (@(posedge clk) disable iff (!rst_n)
        (eol && v_next == line_cmp) |=> (row_scan == '0 && mem_addr == '0));
    // R11: the cursor never shows outside the active area.
    a_r11_cursor_display: assert property (@(posedge clk) disable iff (!rst_n)
        cursor |-> disp_en);
endmodule

// File: rtl/crtc_core.sv
// Top of the raster timing controller: register file, sweep and row addressing.
// Assumes one character per clock and a host that loads the index before data.
module crtc_core
    import crtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_we,
    input  logic          dat_we,
    input  logic [7:0]    wdata,
    output logic [7:0]    h_count,
    output logic [9:0]    v_count,
    output logic          disp_en,
    output logic          hblank,
    output logic          hsync,
    output logic          vblank,
    output logic          vsync,
    output logic          vint,
    output logic [4:0]    row_scan,
    output logic [15:0]   mem_addr,
    output logic          cursor
);
    crtc_cfg_t     cfg;
    logic [VW-1:0] v_next;
    logic          eol;
    logic          eof;

    crtc_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we),
        .wdata(wdata), .cfg(cfg));

    crtc_sweep u_sweep (
        .clk(clk), .rst_n(rst_n),
        .h_total(cfg.h_total), .h_disp_end(cfg.h_disp_end),
        .h_blank_start(cfg.h_blank_start), .h_blank_end(cfg.h_blank_end),
        .h_sync_start(cfg.h_sync_start), .h_sync_end(cfg.h_sync_end),
        .v_total(cfg.v_total), .v_disp_end(cfg.v_disp_end),
        .v_blank_start(cfg.v_blank_start), .v_blank_end(cfg.v_blank_end),
        .v_sync_start(cfg.v_sync_start), .v_sync_end(cfg.v_sync_end),
        .vint_keep(cfg.vint_keep), .vint_dis(cfg.vint_dis),
        .h(h_count), .v(v_count), .v_next(v_next), .eol(eol), .eof(eof),
        .disp_en(disp_en), .hblank(hblank), .hsync(hsync),
        .vblank(vblank), .vsync(vsync), .vint(vint));

    crtc_rowaddr u_row (
        .clk(clk), .rst_n(rst_n), .eol(eol), .eof(eof), .v_next(v_next),
        .h(h_count), .disp_en(disp_en), .line_cmp(cfg.line_cmp),
        .max_scan(cfg.max_scan), .dbl_scan(cfg.dbl_scan),
        .start_addr(cfg.start_addr), .row_offset(cfg.row_offset),
        .cur_addr(cfg.cur_addr), .cur_first(cfg.cur_first),
        .cur_last(cfg.cur_last), .cur_hide(cfg.cur_hide),
        .row_scan(row_scan), .mem_addr(mem_addr), .cursor(cursor));
endmodule

// File: tb/crtc_core_tb_top.sv
module crtc_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        idx_we, dat_we;
    logic [7:0]  wdata;
    logic [7:0]  h_count;
    logic [9:0]  v_count;
    logic        disp_en, hblank, hsync, vblank, vsync, vint, cursor;
    logic [4:0]  row_scan;
    logic [15:0] mem_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crtc_core dut_i (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we),
        .wdata(wdata), .h_count(h_count), .v_count(v_count),
        .disp_en(disp_en), .hblank(hblank), .hsync(hsync),
        .vblank(vblank), .vsync(vsync), .vint(vint),
        .row_scan(row_scan), .mem_addr(mem_addr), .cursor(cursor));

    // Reference state, built from the requirements.
    logic [7:0]  mr [25];
    logic [7:0]  m_idx, m_h;
    logic [9:0]  m_v;
    logic        m_hbq, m_hsq, m_vbq, m_vsq, m_pend, m_dbl;
    logic [4:0]  m_rs;
    logic [15:0] m_base;
    logic        e_hb, e_hs, e_vb, e_vs, e_de, e_cur;
    logic [15:0] e_addr;

    task automatic model_reset();
        for (int i = 0; i < 25; i++) mr[i] = 8'h00;
        m_idx = 0; m_h = 0; m_v = 0; m_hbq = 0; m_hsq = 0; m_vbq = 0;
        m_vsq = 0; m_pend = 0; m_dbl = 0; m_rs = 0; m_base = 0;
    endtask

    task automatic evalc();
        logic [9:0] vbs, vss, vde;
        vbs = {mr[9][5], mr[7][3], mr[21]};
        vss = {mr[7][7], mr[7][2], mr[16]};
        vde = {mr[7][6], mr[7][1], mr[18]};
        e_hb = (m_h == mr[2]) || (m_hbq && (m_h[5:0] != {mr[5][7], mr[3][4:0]}));
        e_hs = (m_h == mr[4]) || (m_hsq && (m_h[4:0] != mr[5][4:0]));
        e_vb = (m_v == vbs) || (m_vbq && (m_v[6:0] != mr[22][6:0]));
        e_vs = (m_v == vss) || (m_vsq && (m_v[3:0] != mr[17][3:0]));
        e_de = (m_h <= mr[1]) && (m_v <= vde);
        e_addr = m_base + {8'h00, m_h};
        e_cur = e_de && !mr[10][5] && (e_addr == {mr[14], mr[15]})
                && (m_rs >= mr[10][4:0]) && (m_rs <= mr[11][4:0]);
    endtask

    task automatic advance(input logic iw, input logic dw, input logic [7:0] d);
        logic [7:0] hl;
        logic [9:0] vl, vn, lc;
        logic eol, eof;
        evalc();
        hl  = mr[0] + 8'd4;
        vl  = {mr[7][5], mr[7][0], mr[6]} + 10'd1;
        lc  = {mr[9][6], mr[7][4], mr[24]};
        eol = (m_h == hl);
        eof = eol && (m_v == vl);
        vn  = eol ? (eof ? 10'd0 : m_v + 10'd1) : m_v;
        if (!mr[17][4]) m_pend = 0;
        else if (e_vs && !m_vsq && !mr[17][5]) m_pend = 1;
        if (eol) begin
            if (vn == lc) begin m_rs = 0; m_dbl = 0; m_base = 0; end
            else if (eof) begin m_rs = 0; m_dbl = 0; m_base = {mr[12], mr[13]}; end
            else if (mr[9][7] && !m_dbl) m_dbl = 1;
            else begin
                m_dbl = 0;
                if (m_rs == mr[9][4:0]) begin m_rs = 0; m_base = m_base + {8'h00, mr[19]}; end
                else m_rs = m_rs + 5'd1;
            end
        end
        m_hbq = e_hb; m_hsq = e_hs; m_vbq = e_vb; m_vsq = e_vs;
        m_h = eol ? 8'd0 : m_h + 8'd1;
        m_v = vn;
        if (dw && m_idx < 8'd25) begin
            if (mr[17][7] && m_idx <= 8'd7) begin
                if (m_idx == 8'd7) mr[7][4] = d[4];
            end else mr[m_idx[4:0]] = d;
        end
        if (iw) m_idx = d;
    endtask

    task automatic chk(input string req, input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, tag, $time, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        evalc();
        chk("R3 h_count", tag, int'(h_count), int'(m_h));
        chk("R3 v_count", tag, int'(v_count), int'(m_v));
        chk("R4 disp_en", tag, int'(disp_en), int'(e_de));
        chk("R5 hblank", tag, int'(hblank), int'(e_hb));
        chk("R6 hsync", tag, int'(hsync), int'(e_hs));
        chk("R7 vblank", tag, int'(vblank), int'(e_vb));
        chk("R8 vsync", tag, int'(vsync), int'(e_vs));
        chk("R8 vint", tag, int'(vint), int'(m_pend));
        chk("R9 row_scan", tag, int'(row_scan), int'(m_rs));
        chk("R9 R10 mem_addr", tag, int'(mem_addr), int'(e_addr));
        chk("R11 cursor", tag, int'(cursor), int'(e_cur));
    endtask

    task automatic cyc(input logic iw, input logic dw, input logic [7:0] d, input string tag);
        @(negedge clk);
        compare(tag);
        idx_we = iw; dat_we = dw; wdata = d;
        advance(iw, dw, d);
    endtask

    task automatic wr(input logic [7:0] ix, input logic [7:0] val, input string tag);
        cyc(1'b1, 1'b0, ix, tag);
        cyc(1'b0, 1'b1, val, tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00, tag);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idx_we = 0; dat_we = 0; wdata = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk("R12 h_count", "reset", int'(h_count), 0);
        chk("R12 v_count", "reset", int'(v_count), 0);
        chk("R12 vint", "reset", int'(vint), 0);
        chk("R12 mem_addr", "reset", int'(mem_addr), 0);
        compare("R12 reset");
        rst_n = 1;
        advance(1'b0, 1'b0, 8'h00);

        // Phase A: small raster, all fields in the low byte.
        wr(8'h00, 8'd6, "R3 A");   wr(8'h01, 8'd6, "R4 A");
        wr(8'h02, 8'd7, "R5 A");   wr(8'h03, 8'd9, "R5 A");
        wr(8'h04, 8'd8, "R6 A");   wr(8'h05, 8'd10, "R6 A");
        wr(8'h06, 8'd9, "R3 A");   wr(8'h07, 8'h10, "R10 A");
        wr(8'h09, 8'h41, "R9 A");  wr(8'h0A, 8'h00, "R11 A");
        wr(8'h0B, 8'h01, "R11 A"); wr(8'h0C, 8'h01, "R9 A");
        wr(8'h0D, 8'h00, "R9 A");  wr(8'h0E, 8'h01, "R11 A");
        wr(8'h0F, 8'h03, "R11 A"); wr(8'h10, 8'd8, "R8 A");
        wr(8'h11, 8'h1A, "R8 A");  wr(8'h12, 8'd7, "R4 A");
        wr(8'h13, 8'd4, "R9 A");   wr(8'h15, 8'd8, "R7 A");
        wr(8'h16, 8'd10, "R7 A");  wr(8'h18, 8'hFF, "R10 A");
        wr(8'h1F, 8'h55, "R1 ignored index");
        run(400, "R1 R3 A");

        // Phase B: overflow bits in use, double scan, split at line 320.
        wr(8'h06, 8'h2C, "R3 B");  wr(8'h12, 8'h00, "R4 B");
        wr(8'h10, 8'h10, "R8 B");  wr(8'h15, 8'h0C, "R7 B");
        wr(8'h16, 8'h16, "R7 B");  wr(8'h18, 8'h40, "R10 B");
        wr(8'h09, 8'hA2, "R9 B");  wr(8'h07, 8'hBF, "R3 B");
        run(9200, "R10 B");

        // Phase C: write protect.
        wr(8'h07, 8'h10, "R3 C");  wr(8'h06, 8'd20, "R3 C");
        wr(8'h12, 8'd15, "R4 C");  wr(8'h10, 8'd17, "R8 C");
        wr(8'h15, 8'd16, "R7 C");  wr(8'h16, 8'd19, "R7 C");
        wr(8'h09, 8'h02, "R9 C");  wr(8'h18, 8'h20, "R10 C");
        wr(8'h11, 8'h9A, "R2 C");
        wr(8'h00, 8'd2, "R2 protected");
        wr(8'h07, 8'h00, "R2 lc bit free");
        wr(8'h18, 8'd5, "R2 R10 C");
        run(600, "R2 C");

        // Phase D: interrupt disable, enable, clear.
        wr(8'h11, 8'h3A, "R8 disabled");  run(300, "R8 disabled");
        wr(8'h11, 8'h1A, "R8 enabled");   run(300, "R8 enabled");
        wr(8'h11, 8'h0A, "R8 cleared");   run(40, "R8 cleared");
        wr(8'h11, 8'h1A, "R8 rearmed");   run(300, "R8 rearmed");

        // Phase E: line compare 0, cursor hide and move.
        wr(8'h18, 8'h00, "R10 E"); run(600, "R10 lc zero");
        wr(8'h0A, 8'h20, "R11 hidden"); run(300, "R11 hidden");
        wr(8'h0A, 8'h00, "R11 E"); wr(8'h0C, 8'h00, "R11 E");
        wr(8'h0E, 8'h00, "R11 E"); wr(8'h0F, 8'h02, "R11 E");
        wr(8'h18, 8'hFF, "R11 E");
        run(600, "R11 moved");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule